// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block collects interrupt requests into two cascaded layers of registers. The first layer is a host-controller status word. Sixteen serial-interrupt lines and nine error pulses set bits in it, and nothing but software clears them. A mask and a global enable reduce that word to one request signal. The request feeds a fixed bit of a second-layer input vector. The second layer latches the masked input into a sticky status word, and any set bit there raises the interrupt output. Because of this, the output can stay high after the original source has gone away.

Software reaches every register over a 32-bit write/read register bus with byte offsets. Writing ones clears bits in both status words. The control word also holds a quiet-mode flag and a start-frame width field, and two firmware-access configuration words sit alongside it. These fields are only stored and read back. The polarity word is stored but has no effect.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset every register reads zero, except the firmware read-size word at offset 0x28, which reads 0x02000000. The interrupt output is low.
- R2: A clock edge that samples serial line n (0..15) high sets first-level status bit 31-n. A low line never clears that bit.
- R3: A write to offset 0x38 clears each first-level status bit written as one. If a source sets the same bit in that cycle, the bit stays set.
- R4: An error pulse on err_i[k] sets first-level status bit k for k = 0..7. A pulse on err_i[8] sets bit 10.
- R5: The cascade request is high only when control bit 31 is set and (status AND mask at 0x34) is non-zero. The request appears as bit 11 of the read-only input word at 0x5C, and every other bit of that word reads zero.
- R6: Each cycle, second-level status (0x50) takes in (input AND mask at 0x54) and keeps those bits until a one is written to them. A bit whose masked input is still high is set again in the same cycle as the clear.
- R7: irq_o is a register. It is high exactly when second-level status is non-zero, so it changes on the same edge as that status, one edge after the request changes.
- R8: The control word at 0x30 stores only bit 31 (enable), bit 30 (quiet mode) and bits 25:24 (start-frame width). Its other bits read zero.
- R9: The words at 0x24, 0x28, 0x34, 0x54 and 0x58 read back as written. The polarity word at 0x58 has no effect on irq_o.
- R10: Reads of any offset other than the ten defined ones return 0xFFFFFFFF, and writes to them change nothing. Offsets 0x40 and 0x5C ignore writes, and 0x40 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ser_i | input | 16 | Serial-interrupt line levels |
| err_i | input | 9 | One-cycle error pulses |
| irq_o | output | 1 | Aggregated interrupt output |

## Verification
The bench builds the block with its default parameters: 16 serial lines, 9 error sources and the cascade on second-level bit 11. With these values, random stimulus can reach every first-level status bit position (31:16, 10 and 7:0) and the fixed cascade position. A reference model tracks every register. Directed sequences cover the cases where set and clear collide, the enable gating, and the sticky second level holding irq_o after the source clears.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
   localparam int OFS_FWSEG  = 'h24;
   localparam int OFS_FWSIZE = 'h28;
   localparam int OFS_CTRL   = 'h30;
   localparam int OFS_L1MASK = 'h34;
   localparam int OFS_L1STAT = 'h38;
   localparam int OFS_ERRADR = 'h40;
   localparam int OFS_L2STAT = 'h50;
   localparam int OFS_L2MASK = 'h54;
   localparam int OFS_L2POL  = 'h58;
   localparam int OFS_L2IN   = 'h5C;

   localparam logic [31:0] CTRL_KEEP  = 32'hC300_0000;
   localparam logic [31:0] FWSIZE_RST = 32'h0200_0000;

   // error source k lands on status bit k, except the ninth source (bit 10)
   function automatic int err_bit(input int k);
      return (k < 8) ? k : 10;
   endfunction
endpackage

// File: rtl/cfg_word.sv
module cfg_word #(
   parameter int          W   = 32,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end
endmodule

// File: rtl/irq_l1_stage.sv
module irq_l1_stage
   import irq_cascade_pkg::*;
#(
   parameter int DW    = 32,
   parameter int SER_N = 16,
   parameter int ERR_N = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SER_N-1:0] ser_i,
   input  logic [ERR_N-1:0] err_i,
   input  logic             wr_ctrl,
   input  logic             wr_mask,
   input  logic             wr_stat,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    ctrl_q,
   output logic [DW-1:0]    mask_q,
   output logic [DW-1:0]    stat_q,
   output logic             req_o
);
   localparam int TOP = DW - 1;

   generate
      if (SER_N > 16) begin : g_bad_ser
         $error("SER_N must not exceed 16");
      end
      if (ERR_N > 9) begin : g_bad_err
         $error("ERR_N must not exceed 9");
      end
      if (DW != 32) begin : g_bad_dw
         $error("DW must be 32");
      end
   endgenerate

   logic [DW-1:0] set_vec;
   logic [DW-1:0] stat_d;

   always_comb begin
      set_vec = '0;
      for (int n = 0; n < SER_N; n++)
         if (ser_i[n]) set_vec[TOP-n] = 1'b1;
      for (int k = 0; k < ERR_N; k++)
         if (err_i[k]) set_vec[err_bit(k)] = 1'b1;
   end

   // hardware set wins over a same-cycle software clear
   assign stat_d = (wr_stat ? (stat_q & ~wdata) : stat_q) | set_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
         stat_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata & CTRL_KEEP;
         if (wr_mask) mask_q <= wdata;
         stat_q <= stat_d;
      end
   end

   assign req_o = ctrl_q[TOP] & (|(stat_q & mask_q));

   for (genvar n = 0; n < SER_N; n++) begin : g_ast_ser
      AST_SER_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
         ser_i[n] |=> stat_q[TOP-n]); // R2
   end

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wdata[0] && !set_vec[0]) |=> !stat_q[0]); // R3

   AST_ERR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      err_i[0] |=> stat_q[0]); // R4
endmodule

// File: rtl/irq_l2_stage.sv
module irq_l2_stage #(
   parameter int DW       = 32,
   parameter int CASC_BIT = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic          wr_stat,
   input  logic          wr_mask,
   input  logic          wr_pol,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] in_vec,
   output logic [DW-1:0] mask_q,
   output logic [DW-1:0] pol_q,
   output logic [DW-1:0] stat_q,
   output logic          irq_o
);
   generate
      if (CASC_BIT >= DW || CASC_BIT < 0) begin : g_bad_bit
         $error("CASC_BIT out of range");
      end
   endgenerate

   logic [DW-1:0] stat_d;

   always_comb begin
      in_vec = '0;
      in_vec[CASC_BIT] = req_i;
   end

   assign stat_d = (wr_stat ? (stat_q & ~wdata) : stat_q) | (in_vec & mask_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         pol_q  <= '0;
         stat_q <= '0;
         irq_o  <= 1'b0;
      end else begin
         if (wr_mask) mask_q <= wdata;
         if (wr_pol)  pol_q  <= wdata;
         stat_q <= stat_d;
         irq_o  <= |stat_d;
      end
   end

   AST_L2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[CASC_BIT] && !(wr_stat && wdata[CASC_BIT])) |=> stat_q[CASC_BIT]); // R6

   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (stat_q != '0)); // R7
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
   import irq_cascade_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int SER_N    = 16,
   parameter int ERR_N    = 9,
   parameter int CASC_BIT = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [SER_N-1:0]  ser_i,
   input  logic [ERR_N-1:0]  err_i,
   output logic              irq_o
);
   localparam int DW = 32;
   localparam logic [ADDR_W-1:0] A_FWSEG  = ADDR_W'(OFS_FWSEG);
   localparam logic [ADDR_W-1:0] A_FWSIZE = ADDR_W'(OFS_FWSIZE);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_L1MASK = ADDR_W'(OFS_L1MASK);
   localparam logic [ADDR_W-1:0] A_L1STAT = ADDR_W'(OFS_L1STAT);
   localparam logic [ADDR_W-1:0] A_ERRADR = ADDR_W'(OFS_ERRADR);
   localparam logic [ADDR_W-1:0] A_L2STAT = ADDR_W'(OFS_L2STAT);
   localparam logic [ADDR_W-1:0] A_L2MASK = ADDR_W'(OFS_L2MASK);
   localparam logic [ADDR_W-1:0] A_L2POL  = ADDR_W'(OFS_L2POL);
   localparam logic [ADDR_W-1:0] A_L2IN   = ADDR_W'(OFS_L2IN);

   generate
      if (ADDR_W < 7) begin : g_bad_aw
         $error("ADDR_W too narrow for the register offsets");
      end
   endgenerate

   logic [DW-1:0] fwseg_q, fwsize_q;
   logic [DW-1:0] l1_ctrl, l1_mask, l1_stat;
   logic [DW-1:0] l2_in, l2_mask, l2_pol, l2_stat;
   logic          l1_req;

   logic wr_fwseg, wr_fwsize, wr_ctrl, wr_l1mask, wr_l1stat;
   logic wr_l2stat, wr_l2mask, wr_l2pol;

   assign wr_fwseg  = bus_we && (bus_addr == A_FWSEG);
   assign wr_fwsize = bus_we && (bus_addr == A_FWSIZE);
   assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
   assign wr_l1mask = bus_we && (bus_addr == A_L1MASK);
   assign wr_l1stat = bus_we && (bus_addr == A_L1STAT);
   assign wr_l2stat = bus_we && (bus_addr == A_L2STAT);
   assign wr_l2mask = bus_we && (bus_addr == A_L2MASK);
   assign wr_l2pol  = bus_we && (bus_addr == A_L2POL);

   cfg_word #(.W(DW), .RST('0)) u_fwseg (
      .clk(clk), .rst_n(rst_n), .we(wr_fwseg), .d(bus_wdata), .q(fwseg_q));

   cfg_word #(.W(DW), .RST(FWSIZE_RST)) u_fwsize (
      .clk(clk), .rst_n(rst_n), .we(wr_fwsize), .d(bus_wdata), .q(fwsize_q));

   irq_l1_stage #(.DW(DW), .SER_N(SER_N), .ERR_N(ERR_N)) u_l1 (
      .clk(clk), .rst_n(rst_n), .ser_i(ser_i), .err_i(err_i),
      .wr_ctrl(wr_ctrl), .wr_mask(wr_l1mask), .wr_stat(wr_l1stat),
      .wdata(bus_wdata), .ctrl_q(l1_ctrl), .mask_q(l1_mask),
      .stat_q(l1_stat), .req_o(l1_req));

   irq_l2_stage #(.DW(DW), .CASC_BIT(CASC_BIT)) u_l2 (
      .clk(clk), .rst_n(rst_n), .req_i(l1_req),
      .wr_stat(wr_l2stat), .wr_mask(wr_l2mask), .wr_pol(wr_l2pol),
      .wdata(bus_wdata), .in_vec(l2_in), .mask_q(l2_mask),
      .pol_q(l2_pol), .stat_q(l2_stat), .irq_o(irq_o));

   always_comb begin
      case (bus_addr)
         A_FWSEG:  bus_rdata = fwseg_q;
         A_FWSIZE: bus_rdata = fwsize_q;
         A_CTRL:   bus_rdata = l1_ctrl;
         A_L1MASK: bus_rdata = l1_mask;
         A_L1STAT: bus_rdata = l1_stat;
         A_ERRADR: bus_rdata = '0;
         A_L2STAT: bus_rdata = l2_stat;
         A_L2MASK: bus_rdata = l2_mask;
         A_L2POL:  bus_rdata = l2_pol;
         A_L2IN:   bus_rdata = l2_in;
         default:  bus_rdata = '1;
      endcase
   end

   AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !l1_ctrl[DW-1] |-> !l2_in[CASC_BIT]); // R5

   AST_CASCADE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (l2_in[CASC_BIT] && l2_mask[CASC_BIT]) |=> l2_stat[CASC_BIT]); // R6
endmodule

// File: tb/tb_irq_cascade_ctrl.sv
module tb_irq_cascade_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] ser_i = '0;
   logic [8:0]  err_i = '0;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] m_ctrl, m_l1m, m_l1s, m_l2m, m_l2s, m_pol, m_seg, m_size;
   logic        m_irq;

   always #10 clk = ~clk;

   irq_cascade_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_i(ser_i),
      .err_i(err_i), .irq_o(irq_o));

   function automatic logic m_req();
      return m_ctrl[31] && ((m_l1s & m_l1m) != 0);
   endfunction

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      case (a)
         8'h24: return m_seg;
         8'h28: return m_size;
         8'h30: return m_ctrl;
         8'h34: return m_l1m;
         8'h38: return m_l1s;
         8'h40: return 32'h0;
         8'h50: return m_l2s;
         8'h54: return m_l2m;
         8'h58: return m_pol;
         8'h5C: return m_req() ? 32'h0000_0800 : 32'h0;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd_chk(input logic [7:0] a, input string tag);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp_rd(a));
   endtask

   task automatic model_reset();
      m_ctrl = 0; m_l1m = 0; m_l1s = 0; m_l2m = 0; m_l2s = 0;
      m_pol = 0; m_seg = 0; m_size = 32'h0200_0000; m_irq = 0;
   endtask

   // one clock with the given stimulus, then check irq_o after the edge
   task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic [15:0] ser, input logic [8:0] err, input string tag);
      logic [31:0] setv, n1, n2;
      bus_we = we; bus_addr = a; bus_wdata = d; ser_i = ser; err_i = err;
      setv = 0;
      for (int n = 0; n < 16; n++) if (ser[n]) setv[31-n] = 1'b1;
      for (int k = 0; k < 9; k++) if (err[k]) setv[(k < 8) ? k : 10] = 1'b1;
      n1 = ((we && a == 8'h38) ? (m_l1s & ~d) : m_l1s) | setv;
      n2 = ((we && a == 8'h50) ? (m_l2s & ~d) : m_l2s)
           | ((m_req() ? 32'h800 : 32'h0) & m_l2m);
      @(posedge clk);
      m_l1s = n1;
      m_l2s = n2;
      m_irq = (n2 != 0);
      if (we) begin
         case (a)
            8'h24: m_seg = d;
            8'h28: m_size = d;
            8'h30: m_ctrl = d & 32'hC300_0000;
            8'h34: m_l1m = d;
            8'h54: m_l2m = d;
            8'h58: m_pol = d;
            default: ;
         endcase
      end
      @(negedge clk);
      bus_we = 1'b0; ser_i = '0; err_i = '0;
      chk(tag, {31'b0, irq_o}, {31'b0, m_irq});
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] offs [12];
      int unsigned seed;
      seed = $urandom(32'h5EED_1234);
      offs = '{8'h24, 8'h28, 8'h30, 8'h34, 8'h38, 8'h40,
               8'h50, 8'h54, 8'h58, 8'h5C, 8'h00, 8'h44};
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
      foreach (offs[i]) rd_chk(offs[i], "R1 reset read");
      // R10 unimplemented and read-only offsets
      rd_chk(8'h00, "R10 hole read");
      step(1'b1, 8'h44, 32'h1234_5678, '0, '0, "R10 hole write");
      rd_chk(8'h44, "R10 hole after write");
      step(1'b1, 8'h40, 32'hDEAD_BEEF, '0, '0, "R10 erradr write");
      rd_chk(8'h40, "R10 erradr read");
      step(1'b1, 8'h5C, 32'hFFFF_FFFF, '0, '0, "R10 input write");
      rd_chk(8'h5C, "R10 input read");
      // R8 control field storage
      step(1'b1, 8'h30, 32'hFFFF_FFFF, '0, '0, "R8 ctrl write");
      rd_chk(8'h30, "R8 ctrl keeps 31,30,25:24");
      step(1'b1, 8'h30, 32'h0, '0, '0, "R8 ctrl clear");
      // R9 read-back words
      step(1'b1, 8'h24, 32'hA5A5_0F0F, '0, '0, "R9 seg");
      step(1'b1, 8'h28, 32'h0700_0000, '0, '0, "R9 size");
      step(1'b1, 8'h58, 32'hFFFF_FFFF, '0, '0, "R9 pol");
      rd_chk(8'h24, "R9 seg read");
      rd_chk(8'h28, "R9 size read");
      rd_chk(8'h58, "R9 pol read");
      // R2 serial line latching, disabled request
      step(1'b0, 8'h00, 0, 16'h0008, '0, "R2 line 3 high");
      rd_chk(8'h38, "R2 bit 28 set");
      step(1'b0, 8'h00, 0, 16'h0000, '0, "R2 line low");
      rd_chk(8'h38, "R2 bit 28 held");
      step(1'b1, 8'h34, 32'h1000_0000, '0, '0, "R5 mask bit 28");
      rd_chk(8'h5C, "R5 gated by enable");
      // R5 enable then R6/R7 cascade
      step(1'b1, 8'h30, 32'h8000_0000, '0, '0, "R5 enable");
      rd_chk(8'h5C, "R5 input bit 11");
      step(1'b0, 8'h00, 0, '0, '0, "R7 l2 mask zero keeps irq low");
      step(1'b1, 8'h54, 32'h0000_0800, '0, '0, "R9 l2 mask");
      step(1'b0, 8'h00, 0, '0, '0, "R7 irq rises");
      chk("R7 irq high", {31'b0, irq_o}, 32'h1);
      step(1'b1, 8'h38, 32'h1000_0000, '0, '0, "R3 clear l1 bit");
      step(1'b0, 8'h00, 0, '0, '0, "R6 sticky");
      chk("R6 irq held after source cleared", {31'b0, irq_o}, 32'h1);
      step(1'b1, 8'h50, 32'h0000_0800, '0, '0, "R6 clear l2");
      chk("R7 irq low after clear", {31'b0, irq_o}, 32'h0);
      // R3 set wins over clear
      step(1'b1, 8'h38, 32'h8000_0000, 16'h0001, '0, "R3 collide");
      rd_chk(8'h38, "R3 set wins");
      step(1'b1, 8'h38, 32'h8000_0000, '0, '0, "R3 clear");
      rd_chk(8'h38, "R3 cleared");
      // R4 error sources
      step(1'b0, 8'h00, 0, '0, 9'h1FF, "R4 all errors");
      rd_chk(8'h38, "R4 bits 10,7:0");
      step(1'b1, 8'h38, 32'hFFFF_FFFF, '0, '0, "R3 clear all");
      rd_chk(8'h38, "R3 all clear");
      // random phase
      for (int it = 0; it < 600; it++) begin
         logic [7:0]  a;
         logic [15:0] s;
         logic [8:0]  e;
         logic        w;
         logic [31:0] d;
         a = offs[$urandom % 12];
         w = ($urandom % 2) == 0;
         d = $urandom;
         if (a == 8'h30 && ($urandom % 2) == 0) d[31] = 1'b1;
         s = (($urandom % 4) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
         e = (($urandom % 5) == 0) ? (9'h1 << ($urandom % 9)) : 9'h0;
         step(w, a, d, s, e, "R6 R7 random irq");
         rd_chk(offs[$urandom % 12], "R2 R3 R4 R5 R9 R10 random read");
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule